// File: doc/BRIEF.md
# Multiplier-Free Four-Tap FIR Filter with Folded Offset-Coded Table

The block filters a stream of signed samples with a four-tap FIR whose coefficients are fixed when it is built. No multiplier is used. Each accepted sample shifts into a four-word history. The filter then walks the bit positions of those four words one per clock, from the most significant bit down. The four bits found at one position form a 4-bit address into a small coefficient table. The table is recoded so that every address gives half of a signed sum of all four coefficients, each coefficient taken as plus or minus. Because an address and its bitwise complement give values of opposite sign, only eight words are stored.

The looked-up value is registered before it is used, so a table read and an accumulation never fall in the same cycle. Partial values are doubled and added in a carry-save accumulator that keeps the sum and carry vectors apart. After the last bit position, one carry-propagate add merges the two vectors with a constant correction. That add produces the filter output, which is presented for a single cycle.

The word length `DW` is 8 or 16. The coefficients are integer parameters `COEF0` to `COEF3`, each fitting in `CW` signed bits. A sample handshake holds off new input while the block walks the bits of the current one.

Top module: `obc_da_fir`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0, `out_data` is 0 and `in_ready` is 1. Reset empties the history, so every tap reads zero.
- R2: Each result equals COEF0*x0 + COEF1*x1 + COEF2*x2 + COEF3*x3, taken as signed integers. Here x0 is the sample just accepted and x1 to x3 are the three accepted before it. A sample is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. Table address bit k is the current bit of tap xk.
- R3: `out_valid` is 1 for exactly one cycle. It rises after the edge that comes DW+2 edges after the accepting edge, and it never rises without such an acceptance.
- R4: `in_ready` drops to 0 right after an acceptance, stays at 0 for DW cycles and then returns to 1. A value presented on `in_data` while `in_ready` is 0 has no effect on the history or on any later result.
- R5: A new sample can be accepted DW+1 edges after the previous one while the previous result is still being finished. Both results are then correct.
- R6: The output has DW+CW+2 bits and never wraps, even at full-scale inputs such as -2^(DW-1) on every tap.
- R7: Between result pulses, `out_data` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_data | input | DW | Signed sample |
| in_ready | output | 1 | Block can accept a sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DW+CW+2 | Signed filter result |

## Verification
When the next sample is offered as soon as `in_ready` returns, its acceptance falls in the same cycle as the last carry-save step of the previous sample. Its first table read then coincides with the final carry-propagate add that produces the previous output. The bench provokes this by holding `in_valid` high over long runs, so that every acceptance lands on the earliest edge. A behavioural queue of expected dot products, each tagged with the edge at which it falls due, judges every cycle. That queue catches any result that is late, early, missing or corrupted by the overlap.

// File: rtl/obc_da_pkg.sv
package obc_da_pkg;

    localparam int TAPS = 4;
    localparam int HALF_ENTRIES = 8;

    // Signed sum of the four coefficients, each taken as +c when its
    // address bit is 1 and -c when it is 0 (value carries one fraction bit,
    // i.e. it stands for half of itself).
    function automatic int da_entry(input int idx, input int c0, input int c1,
                                    input int c2, input int c3);
        int acc;
        acc = 0;
        acc += ((idx & 1) != 0) ? c0 : -c0;
        acc += ((idx & 2) != 0) ? c1 : -c1;
        acc += ((idx & 4) != 0) ? c2 : -c2;
        acc += ((idx & 8) != 0) ? c3 : -c3;
        return acc;
    endfunction

endpackage

// File: rtl/obc_da_taps.sv
module obc_da_taps #(
    parameter int DW = 8,
    localparam int IW = $clog2(DW),
    localparam int NT = obc_da_pkg::TAPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic [DW-1:0] sample,
    input  logic [IW-1:0] bit_sel,
    output logic [NT-1:0] slice
);

    typedef struct packed {
        logic [NT-1:0][DW-1:0] word;
    } taps_t;

    taps_t taps_d, taps_q;

    always_comb begin
        taps_d = taps_q;
        if (shift_en) begin
            taps_d.word[0] = sample;
            for (int k = 1; k < NT; k++) begin
                taps_d.word[k] = taps_q.word[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q <= '0;
        end else begin
            taps_q <= taps_d;
        end
    end

    for (genvar k = 0; k < NT; k++) begin : g_slice
        assign slice[k] = taps_q.word[k][bit_sel];
    end

endmodule

// File: rtl/obc_da_lut.sv
module obc_da_lut #(
    parameter int CW = 10,
    parameter int COEF0 = 93,
    parameter int COEF1 = -211,
    parameter int COEF2 = 511,
    parameter int COEF3 = -512,
    localparam int TW = CW + 3,
    localparam int NE = obc_da_pkg::HALF_ENTRIES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [3:0]    addr,
    input  logic          first,
    input  logic          last,
    output logic          p_vld,
    output logic [TW-1:0] p_val,
    output logic          p_neg,
    output logic          p_first,
    output logic          p_last
);

    typedef struct packed {
        logic          vld;
        logic [TW-1:0] val;
        logic          neg;
        logic          first;
        logic          last;
    } pipe_t;

    logic [TW-1:0] rom [NE];

    for (genvar i = 0; i < NE; i++) begin : g_entry
        localparam int ENT = obc_da_pkg::da_entry(i, COEF0, COEF1, COEF2, COEF3);
        assign rom[i] = TW'(ENT);
    end

    pipe_t pipe_d, pipe_q;
    logic [2:0] lut_idx;

    always_comb begin
        // upper half of the address space is folded onto the lower half
        lut_idx = addr[3] ? ~addr[2:0] : addr[2:0];
        pipe_d.vld = issue;
        pipe_d.val = rom[lut_idx];
        // folded entry negated; sign bit slice subtracted
        pipe_d.neg = addr[3] ^ first;
        pipe_d.first = first;
        pipe_d.last = last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign p_vld   = pipe_q.vld;
    assign p_val   = pipe_q.val;
    assign p_neg   = pipe_q.neg;
    assign p_first = pipe_q.first;
    assign p_last  = pipe_q.last;

endmodule

// File: rtl/obc_da_csa_acc.sv
module obc_da_csa_acc #(
    parameter int TW = 13,
    parameter int YW = 20,
    parameter int OFFSET = 0,
    localparam int AW = YW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          p_vld,
    input  logic [TW-1:0] p_val,
    input  logic          p_neg,
    input  logic          p_first,
    input  logic          p_last,
    output logic          res_vld,
    output logic [YW-1:0] res_data
);

    localparam logic [AW-1:0] OFFV = AW'(OFFSET);

    typedef struct packed {
        logic [AW-1:0] s;
        logic [AW-1:0] c;
        logic          done;
        logic          ovld;
        logic [YW-1:0] odata;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [AW-1:0] ext, z, sh_s, sh_c, total;
    logic unused_lsb;

    always_comb begin
        acc_d = acc_q;
        ext = {{(AW-TW){p_val[TW-1]}}, p_val};
        z = p_neg ? ~ext : ext;
        sh_s = p_first ? '0 : {acc_q.s[AW-2:0], 1'b0};
        sh_c = p_first ? '0 : {acc_q.c[AW-2:0], 1'b0};
        sh_c[0] = p_neg;                      // +1 completes the negation
        if (p_vld) begin
            acc_d.s = sh_s ^ sh_c ^ z;
            acc_d.c = {((sh_s[AW-2:0] & sh_c[AW-2:0]) |
                        (sh_s[AW-2:0] & z[AW-2:0])    |
                        (sh_c[AW-2:0] & z[AW-2:0])), 1'b0};
        end
        acc_d.done = p_vld & p_last;
        // carry-propagate merge with the constant correction
        total = acc_q.s + acc_q.c + OFFV;
        acc_d.ovld = acc_q.done;
        if (acc_q.done) begin
            acc_d.odata = total[AW-1:1];
        end
    end

    assign unused_lsb = total[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign res_vld  = acc_q.ovld;
    assign res_data = acc_q.odata;

endmodule

// File: rtl/obc_da_fir.sv
module obc_da_fir #(
    parameter int DW = 8,
    parameter int CW = 10,
    parameter int COEF0 = 93,
    parameter int COEF1 = -211,
    parameter int COEF2 = 511,
    parameter int COEF3 = -512,
    localparam int YW = DW + CW + 2,
    localparam int TW = CW + 3,
    localparam int IW = $clog2(DW),
    localparam int NT = obc_da_pkg::TAPS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [YW-1:0] out_data
);

    localparam int OFFSET = -(COEF0 + COEF1 + COEF2 + COEF3);
    localparam logic [IW-1:0] TOP_BIT = IW'(DW - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept;
    logic [NT-1:0] slice;
    logic p_vld, p_neg, p_first, p_last;
    logic [TW-1:0] p_val;

    always_comb begin
        seq_d = seq_q;
        accept = in_valid & ~seq_q.busy;
        if (accept) begin
            seq_d.busy = 1'b1;
            seq_d.cnt = TOP_BIT;
        end else if (seq_q.busy) begin
            if (seq_q.cnt == '0) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign in_ready = ~seq_q.busy;

    obc_da_taps #(.DW(DW)) u_taps (
        .clk(clk), .rst_n(rst_n), .shift_en(accept), .sample(in_data),
        .bit_sel(seq_q.cnt), .slice(slice)
    );

    obc_da_lut #(
        .CW(CW), .COEF0(COEF0), .COEF1(COEF1), .COEF2(COEF2), .COEF3(COEF3)
    ) u_lut (
        .clk(clk), .rst_n(rst_n), .issue(seq_q.busy), .addr(slice),
        .first(seq_q.busy && seq_q.cnt == TOP_BIT),
        .last(seq_q.busy && seq_q.cnt == '0),
        .p_vld(p_vld), .p_val(p_val), .p_neg(p_neg),
        .p_first(p_first), .p_last(p_last)
    );

    obc_da_csa_acc #(.TW(TW), .YW(YW), .OFFSET(OFFSET)) u_acc (
        .clk(clk), .rst_n(rst_n), .p_vld(p_vld), .p_val(p_val), .p_neg(p_neg),
        .p_first(p_first), .p_last(p_last),
        .res_vld(out_valid), .res_data(out_data)
    );

endmodule

// File: rtl/obc_da_fir_chk.sv
module obc_da_fir_chk #(
    parameter int DW = 8,
    parameter int YW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic [YW-1:0] out_data
);

    // hist[i] set: a sample was accepted i+1 edges ago
    logic [DW+2:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[DW+1:0], in_valid & in_ready};
        end
    end

    p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_ready_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hist[DW-1:0]) |-> !in_ready);

    p_ready_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hist[DW] |-> in_ready);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hist[DW+2] |-> out_valid);

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> hist[DW+2]);

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

bind obc_da_fir obc_da_fir_chk #(.DW(DW), .YW(YW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data)
);

// File: tb/obc_da_fir_tb.sv
module obc_da_fir_tb;

    localparam int DW = 8;
    localparam int CW = 10;
    localparam int YW = DW + CW + 2;
    localparam int C0 = 93, C1 = -211, C2 = 511, C3 = -512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic signed [YW-1:0] out_data;

    obc_da_fir #(.DW(DW), .CW(CW), .COEF0(C0), .COEF1(C1), .COEF2(C2), .COEF3(C3)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    longint cyc = 0;
    int n_chk = 0, n_fail = 0;
    bit mon_en = 1'b0;
    string phase = "R2";
    longint x [4] = '{0, 0, 0, 0};
    longint exp_val [$];
    longint exp_due [$];
    string  exp_tag [$];
    longint last_acc_edge = -1000;
    longint last_out = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, expv, cyc);
        end
    endtask

    // called at a negedge; returns at the negedge after the accepting edge
    task automatic send(input logic signed [DW-1:0] v);
        in_valid = 1'b1;
        in_data = v;
        while (!in_ready) @(negedge clk);
        x[3] = x[2]; x[2] = x[1]; x[1] = x[0]; x[0] = longint'(v);
        exp_val.push_back(C0 * x[0] + C1 * x[1] + C2 * x[2] + C3 * x[3]);
        exp_due.push_back(cyc + 1 + DW + 2);
        exp_tag.push_back(phase);
        last_acc_edge = cyc + 1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // offer a junk sample while the block is busy (R4: must be ignored)
    task automatic poke_busy(input logic signed [DW-1:0] junk);
        in_valid = 1'b1;
        in_data = junk;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        #2;
        if (mon_en) begin
            bit due;
            check(in_ready == ((cyc - last_acc_edge) >= DW), "R4 ready",
                  longint'(in_ready), longint'((cyc - last_acc_edge) >= DW));
            due = (exp_due.size() > 0) && (exp_due[0] == cyc);
            check(out_valid == due, "R3 valid timing", longint'(out_valid), longint'(due));
            if (due) begin
                if (out_valid) begin
                    check(longint'(out_data) == exp_val[0], exp_tag[0],
                          longint'(out_data), exp_val[0]);
                    last_out = longint'(out_data);
                end
                void'(exp_val.pop_front());
                void'(exp_due.pop_front());
                void'(exp_tag.pop_front());
            end else if (!out_valid) begin
                check(longint'(out_data) == last_out, "R7 hold", longint'(out_data), last_out);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R1 ready in reset", longint'(in_ready), 1);
        check(longint'(out_data) == 0, "R1 data in reset", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);
        check(in_ready == 1'b1, "R1 ready after reset", longint'(in_ready), 1);
        mon_en = 1'b1;

        // impulse: outputs step through the coefficients
        phase = "R2 impulse";
        send(8'sd1);
        repeat (3) begin
            repeat (4) @(negedge clk);
            send(8'sd0);
        end
        repeat (DW + 4) @(negedge clk);

        // random samples, gaps and junk offered while busy
        phase = "R2/R4 random";
        for (int i = 0; i < 40; i++) begin
            send(DW'($urandom));
            if (i % 3 == 0) poke_busy(DW'($urandom));
            repeat ($urandom_range(0, 12)) @(negedge clk);
        end

        // full-scale values
        phase = "R6 extremes";
        repeat (4) send(-8'sd128);
        repeat (4) send(8'sd127);
        for (int i = 0; i < 8; i++) send((i % 2 == 0) ? -8'sd128 : 8'sd127);
        repeat (4) send(-8'sd128);

        // earliest possible acceptance every time
        phase = "R5 back-to-back";
        for (int i = 0; i < 30; i++) send(DW'($urandom));

        repeat (DW + 8) @(negedge clk);
        check(exp_val.size() == 0, "R3 all results delivered", longint'(exp_val.size()), 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule